// File: doc/BRIEF.md
# Packet-Counted Output Queue Bank with Event Trace

This block sits at the egress end of a packet pipeline. Packets arrive one 64-bit word per cycle on a data-plus-control bus. The first word of each packet is a module header that names one of eight destination queues. Each queue holds whole packets in its own small word array.

Each queue stores at most a run-time programmable number of packets. A packet that arrives while its queue is at that limit is thrown away. A packet that does not fit in the free word space is also thrown away. The downstream side pulls words from any queue that holds at least one complete packet. Each queue reports its current packet count on an output.

For tracing occupancy over time, the block can emit an event record for every packet stored, removed or dropped in a monitored queue. Each record carries a timestamp from a free-running cycle counter. Up to two records leave per cycle on two lanes.

Top module: `pktq_bank`

## Requirements
- R1: While reset is asserted and after it is released, every queue count reads 0, `deq_valid` is 0 and `evt_valid` is 0.
- R2: A word whose control byte is 8'hFF is a header. Bits [50:48] of its data select the queue and bits [15:0] give the packet length in words, header included. An accepted packet's words, with their control bytes, come out of that queue in arrival order. `deq_en` with `deq_sel` set to a queue that holds a complete packet presents the next word on `deq_data`/`deq_ctrl` with `deq_valid` high one cycle later.
- R3: A non-header word whose control byte is nonzero is the last word of its packet. A queue's count rises by one in the cycle after its last word is accepted, and falls by one in the cycle after its last word is dequeued.
- R4: A header for a queue whose count is at least min(limit, MAX_PKTS) is rejected. The limit is the queue's field of `q_limit`, which is CNT_W bits per queue with queue 0 in the low bits. All words of a rejected packet are consumed without being stored, and the count is unchanged.
- R5: A header whose length field exceeds the queue's free word space is rejected in the same way.
- R6: `deq_en` aimed at a queue whose count is 0 has no effect: `deq_valid` stays 0 and no count changes.
- R7: An event record is 53 bits: timestamp [52:21], length [20:5], type [4:3] and queue [2:0]. The type codes are 1 for store, 2 for remove and 3 for drop. Lane 0 occupies `evt_rec[52:0]` and lane 1 occupies `evt_rec[105:53]`. A record appears one cycle after the word that caused it.
- R8: A store record is raised on an accepted last word, with length equal to the number of words stored. A remove record is raised on a dequeued last word, with length equal to the number of words dequeued for that packet. A drop record is raised on a rejected header, with length equal to the header's length field.
- R9: A record is raised only when `mon_all` is 1 and the queue's bit in `mon_mask` is 1. Otherwise nothing is raised, and the queue operates unchanged.
- R10: When a remove record and a store or drop record arise in the same cycle, the remove record goes on lane 0 and the other on lane 1. A lone record always uses lane 0, so `evt_valid` is 00, 01 or 11.
- R11: The timestamp is 0 in the first cycle after reset and rises by one every cycle. A record carries the value the counter held at the clock edge that took the causing word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_wr | input | 1 | Input word valid |
| in_data | input | 64 | Input data word |
| in_ctrl | input | 8 | Input control byte (8'hFF header, 0 body, other values last) |
| q_limit | input | 8*CNT_W | Per-queue packet limit |
| mon_all | input | 1 | Global event enable |
| mon_mask | input | 8 | Per-queue event enable |
| deq_en | input | 1 | Dequeue one word |
| deq_sel | input | 3 | Queue to dequeue from |
| deq_valid | output | 1 | Dequeued word valid |
| deq_data | output | 64 | Dequeued data word |
| deq_ctrl | output | 8 | Dequeued control byte |
| occ | output | 8*CNT_W | Per-queue stored packet count |
| evt_valid | output | 2 | Event lane valid bits |
| evt_rec | output | 106 | Two event records |

## Verification
Every result of this block is due exactly one clock edge after its cause. This covers the dequeued word, the count change after a last word moves, and each store, remove or drop record. The bench drives each cycle's stimulus at the falling edge and predicts the outcome from its own packet model. It compares all outputs at the following falling edge, so each prediction is checked against the single edge that must produce it. Directed sequences line up a remove and a store in one cycle, fill a queue to its packet limit and to its word space, dequeue an empty queue, and mask events.

// File: rtl/pktq_pkg.sv
package pktq_pkg;
    localparam int NQ       = 8;
    localparam int QI_W     = 3;
    localparam int DW       = 64;
    localparam int CTW      = 8;
    localparam int WW       = DW + CTW;
    localparam int LEN_W    = 16;
    localparam int TS_W     = 32;
    localparam int DEST_LSB = 48;
    localparam logic [CTW-1:0] HDR_CTRL = 8'hFF;

    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_STORE  = 2'd1,
        EV_REMOVE = 2'd2,
        EV_DROP   = 2'd3
    } ev_kind_e;

    typedef struct packed {
        logic [TS_W-1:0]  ts;
        logic [LEN_W-1:0] len;
        ev_kind_e         kind;
        logic [QI_W-1:0]  q;
    } ev_rec_t;

    localparam int REC_W = $bits(ev_rec_t);
endpackage

// File: rtl/pktq_store.sv
module pktq_store
    import pktq_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int MAX_PKTS = 16,
    parameter int CNT_W    = 5,
    parameter int AW       = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WW-1:0]    wr_word,
    input  logic             wr_last,
    input  logic             rd_en,
    output logic [WW-1:0]    rd_word,
    output logic             rd_last,
    output logic [LEN_W-1:0] rd_len,
    output logic [CNT_W-1:0] pkt_cnt,
    output logic [AW:0]      used
);
    typedef struct packed {
        logic [AW-1:0]    wp;
        logic [AW-1:0]    rp;
        logic [AW:0]      used;
        logic [CNT_W-1:0] cnt;
        logic [LEN_W-1:0] rdn;
    } st_t;

    st_t st_q, st_d;
    logic [WW-1:0]  mem [DEPTH];
    logic [CTW-1:0] rd_ctrl;

    assign rd_word = mem[st_q.rp];
    assign rd_ctrl = rd_word[WW-1 -: CTW];
    assign rd_last = (rd_ctrl != '0) && (rd_ctrl != HDR_CTRL);
    assign rd_len  = st_q.rdn + LEN_W'(1);
    assign pkt_cnt = st_q.cnt;
    assign used    = st_q.used;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.wp   = st_q.wp + AW'(1);
            st_d.used = st_d.used + (AW+1)'(1);
            if (wr_last) st_d.cnt = st_d.cnt + CNT_W'(1);
        end
        if (rd_en) begin
            st_d.rp   = st_q.rp + AW'(1);
            st_d.used = st_d.used - (AW+1)'(1);
            if (rd_last) begin
                st_d.cnt = st_d.cnt - CNT_W'(1);
                st_d.rdn = '0;
            end else begin
                st_d.rdn = st_q.rdn + LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[st_q.wp] <= wr_word;
    end

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (st_q.used < (AW+1)'(DEPTH)));
    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (st_q.cnt != '0));
    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(MAX_PKTS));
endmodule

// File: rtl/pktq_ingress.sv
module pktq_ingress
    import pktq_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int MAX_PKTS = 16,
    parameter int CNT_W    = 5,
    parameter int AW       = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_wr,
    input  logic [DW-1:0]              in_data,
    input  logic [CTW-1:0]             in_ctrl,
    input  logic [NQ-1:0][CNT_W-1:0]   lim_all,
    input  logic [NQ-1:0][CNT_W-1:0]   cnt_all,
    input  logic [NQ-1:0][AW:0]        used_all,
    output logic [NQ-1:0]              wr_en,
    output logic [WW-1:0]              wr_word,
    output logic                       wr_last,
    output logic                       ev_v,
    output ev_kind_e                   ev_kind,
    output logic [QI_W-1:0]            ev_q,
    output logic [LEN_W-1:0]           ev_len
);
    typedef enum logic [1:0] { M_IDLE, M_KEEP, M_TOSS } mode_e;

    typedef struct packed {
        mode_e            mode;
        logic [QI_W-1:0]  q;
        logic [LEN_W-1:0] wn;
    } st_t;

    st_t st_q, st_d;

    logic             is_hdr, is_last, reject;
    logic [QI_W-1:0]  dest;
    logic [LEN_W-1:0] hlen, free_w;
    logic [CNT_W-1:0] lim_sel, eff_lim;

    assign wr_word = {in_ctrl, in_data};
    assign is_hdr  = (in_ctrl == HDR_CTRL);
    assign is_last = (in_ctrl != '0) && !is_hdr;
    assign dest    = in_data[DEST_LSB +: QI_W];
    assign hlen    = in_data[LEN_W-1:0];
    assign lim_sel = lim_all[dest];
    assign eff_lim = (lim_sel > CNT_W'(MAX_PKTS)) ? CNT_W'(MAX_PKTS) : lim_sel;
    assign free_w  = LEN_W'(DEPTH) - LEN_W'(used_all[dest]);
    assign reject  = (cnt_all[dest] >= eff_lim) || (hlen > free_w);

    always_comb begin
        st_d    = st_q;
        wr_en   = '0;
        wr_last = 1'b0;
        ev_v    = 1'b0;
        ev_kind = EV_STORE;
        ev_q    = dest;
        ev_len  = hlen;
        case (st_q.mode)
            M_IDLE: begin
                if (in_wr && is_hdr) begin
                    if (reject) begin
                        ev_v      = 1'b1;
                        ev_kind   = EV_DROP;
                        st_d.mode = M_TOSS;
                    end else begin
                        wr_en[dest] = 1'b1;
                        st_d.mode   = M_KEEP;
                        st_d.q      = dest;
                        st_d.wn     = LEN_W'(1);
                    end
                end
            end
            M_KEEP: begin
                if (in_wr) begin
                    wr_en[st_q.q] = 1'b1;
                    st_d.wn       = st_q.wn + LEN_W'(1);
                    if (is_last) begin
                        wr_last   = 1'b1;
                        ev_v      = 1'b1;
                        ev_kind   = EV_STORE;
                        ev_q      = st_q.q;
                        ev_len    = st_q.wn + LEN_W'(1);
                        st_d.mode = M_IDLE;
                    end
                end
            end
            default: begin
                if (in_wr && is_last) st_d.mode = M_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{mode: M_IDLE, q: '0, wn: '0};
        else        st_q <= st_d;
    end

    // R2
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));
    // R4
    toss_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_TOSS) |-> (wr_en == '0));
endmodule

// File: rtl/pktq_event.sv
module pktq_event
    import pktq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mon_all,
    input  logic [NQ-1:0]      mon_mask,
    input  logic               rd_v,
    input  logic [QI_W-1:0]    rd_q,
    input  logic [LEN_W-1:0]   rd_len,
    input  logic               wd_v,
    input  ev_kind_e           wd_kind,
    input  logic [QI_W-1:0]    wd_q,
    input  logic [LEN_W-1:0]   wd_len,
    output logic [1:0]         evt_valid,
    output logic [2*REC_W-1:0] evt_rec
);
    typedef struct packed {
        logic [TS_W-1:0] ts;
        logic [1:0]      vld;
        ev_rec_t         r0;
        ev_rec_t         r1;
    } st_t;

    st_t     st_q, st_d;
    logic    r_on, w_on;
    ev_rec_t rec_rd, rec_wd;

    assign r_on   = rd_v && mon_all && mon_mask[rd_q];
    assign w_on   = wd_v && mon_all && mon_mask[wd_q];
    assign rec_rd = '{ts: st_q.ts, len: rd_len, kind: EV_REMOVE, q: rd_q};
    assign rec_wd = '{ts: st_q.ts, len: wd_len, kind: wd_kind,   q: wd_q};

    always_comb begin
        st_d    = st_q;
        st_d.ts = st_q.ts + TS_W'(1);
        st_d.r1 = '0;
        if (r_on) begin
            st_d.vld = {w_on, 1'b1};
            st_d.r0  = rec_rd;
            st_d.r1  = w_on ? rec_wd : '0;
        end else begin
            st_d.vld = {1'b0, w_on};
            st_d.r0  = w_on ? rec_wd : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt_valid = st_q.vld;
    assign evt_rec   = {st_q.r1, st_q.r0};

    // R10
    lane_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid[1] |-> evt_valid[0]);
    // R10
    lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid[1] |-> (st_q.r0.kind == EV_REMOVE));
endmodule

// File: rtl/pktq_bank.sv
module pktq_bank
    import pktq_pkg::*;
#(
    parameter int Q_WORDS  = 64,
    parameter int MAX_PKTS = 16,
    localparam int AW      = $clog2(Q_WORDS),
    localparam int CNT_W   = $clog2(MAX_PKTS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_wr,
    input  logic [63:0]           in_data,
    input  logic [7:0]            in_ctrl,
    input  logic [8*CNT_W-1:0]    q_limit,
    input  logic                  mon_all,
    input  logic [7:0]            mon_mask,
    input  logic                  deq_en,
    input  logic [2:0]            deq_sel,
    output logic                  deq_valid,
    output logic [63:0]           deq_data,
    output logic [7:0]            deq_ctrl,
    output logic [8*CNT_W-1:0]    occ,
    output logic [1:0]            evt_valid,
    output logic [2*REC_W-1:0]    evt_rec
);
    typedef struct packed {
        logic          dv;
        logic [WW-1:0] dw;
    } st_t;

    st_t st_q, st_d;

    logic [NQ-1:0][CNT_W-1:0] lim_all, cnt_all;
    logic [NQ-1:0][AW:0]      used_all;
    logic [NQ-1:0][WW-1:0]    rdw_all;
    logic [NQ-1:0][LEN_W-1:0] rlen_all;
    logic [NQ-1:0]            rlast_all, wr_en, rd_en;
    logic [WW-1:0]            wr_word;
    logic                     wr_last, wd_v, rd_v, sel_ready;
    ev_kind_e                 wd_kind;
    logic [QI_W-1:0]          wd_q;
    logic [LEN_W-1:0]         wd_len;

    assign lim_all   = q_limit;
    assign occ       = cnt_all;
    assign sel_ready = deq_en && (cnt_all[deq_sel] != '0);
    assign rd_v      = sel_ready && rlast_all[deq_sel];

    always_comb begin
        rd_en          = '0;
        rd_en[deq_sel] = sel_ready;
    end

    pktq_ingress #(
        .DEPTH(Q_WORDS), .MAX_PKTS(MAX_PKTS), .CNT_W(CNT_W), .AW(AW)
    ) u_ingress (
        .clk(clk), .rst_n(rst_n), .in_wr(in_wr), .in_data(in_data), .in_ctrl(in_ctrl),
        .lim_all(lim_all), .cnt_all(cnt_all), .used_all(used_all),
        .wr_en(wr_en), .wr_word(wr_word), .wr_last(wr_last),
        .ev_v(wd_v), .ev_kind(wd_kind), .ev_q(wd_q), .ev_len(wd_len)
    );

    for (genvar gi = 0; gi < NQ; gi++) begin : g_queue
        pktq_store #(
            .DEPTH(Q_WORDS), .MAX_PKTS(MAX_PKTS), .CNT_W(CNT_W), .AW(AW)
        ) u_store (
            .clk(clk), .rst_n(rst_n),
            .wr_en(wr_en[gi]), .wr_word(wr_word), .wr_last(wr_last),
            .rd_en(rd_en[gi]), .rd_word(rdw_all[gi]), .rd_last(rlast_all[gi]),
            .rd_len(rlen_all[gi]), .pkt_cnt(cnt_all[gi]), .used(used_all[gi])
        );
    end

    pktq_event u_event (
        .clk(clk), .rst_n(rst_n), .mon_all(mon_all), .mon_mask(mon_mask),
        .rd_v(rd_v), .rd_q(deq_sel), .rd_len(rlen_all[deq_sel]),
        .wd_v(wd_v), .wd_kind(wd_kind), .wd_q(wd_q), .wd_len(wd_len),
        .evt_valid(evt_valid), .evt_rec(evt_rec)
    );

    always_comb begin
        st_d.dv = sel_ready;
        st_d.dw = sel_ready ? rdw_all[deq_sel] : st_q.dw;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign deq_valid = st_q.dv;
    assign deq_ctrl  = st_q.dw[WW-1 -: CTW];
    assign deq_data  = st_q.dw[DW-1:0];

    // R6
    empty_deq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_en && (cnt_all[deq_sel] == '0)) |=> !deq_valid);
endmodule

// File: tb/pktq_bank_test.sv
module pktq_bank_test;
    localparam int CLK_PERIOD = 10;
    localparam int D = 64;
    localparam int MAXP = 16;
    localparam int CW = 5;
    localparam int RW = 53;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_wr = 1'b0;
    logic [63:0] in_data = '0;
    logic [7:0] in_ctrl = '0;
    logic [8*CW-1:0] q_limit;
    logic mon_all = 1'b1;
    logic [7:0] mon_mask = 8'hFF;
    logic deq_en = 1'b0;
    logic [2:0] deq_sel = '0;
    logic deq_valid;
    logic [63:0] deq_data;
    logic [7:0] deq_ctrl;
    logic [8*CW-1:0] occ;
    logic [1:0] evt_valid;
    logic [2*RW-1:0] evt_rec;

    pktq_bank uut (
        .clk(clk), .rst_n(rst_n), .in_wr(in_wr), .in_data(in_data), .in_ctrl(in_ctrl),
        .q_limit(q_limit), .mon_all(mon_all), .mon_mask(mon_mask),
        .deq_en(deq_en), .deq_sel(deq_sel), .deq_valid(deq_valid),
        .deq_data(deq_data), .deq_ctrl(deq_ctrl), .occ(occ),
        .evt_valid(evt_valid), .evt_rec(evt_rec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    int tcnt = 0;
    int lim [8];

    // bench packet model
    logic [71:0] mmem [8][D];
    int mh [8], mt [8], mused [8], mcnt [8], mrdn [8];
    int mode = 0, mcur = 0, mwn = 0;
    logic e_dv;
    logic [71:0] e_dw;
    logic [1:0] e_ev;
    logic [RW-1:0] e_r0, e_r1;

    int p_left = 0, p_q = 0, p_len = 0, p_idx = 0;

    always @(posedge clk) begin
        if (!rst_n) tcnt <= 0;
        else tcnt <= tcnt + 1;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL R1 watchdog: cycles=%0d expected below 150000", cyc);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [71:0] mkw(int q, int len, int idx);
        logic [71:0] w;
        w[63:0] = {$urandom, $urandom};
        if (idx == 0) begin
            w[71:64] = 8'hFF;
            w[50:48] = 3'(q);
            w[15:0]  = 16'(len);
        end else if (idx == len - 1) begin
            w[71:64] = 8'($urandom_range(1, 254));
        end else begin
            w[71:64] = 8'h00;
        end
        return w;
    endfunction

    function automatic logic [RW-1:0] mkrec(int ts, int len, int kind, int q);
        return {32'(ts), 16'(len), 2'(kind), 3'(q)};
    endfunction

    function automatic logic [CW-1:0] occ_of(int q);
        return occ[q*CW +: CW];
    endfunction

    task automatic drive_limits();
        for (int i = 0; i < 8; i++) q_limit[i*CW +: CW] = CW'(lim[i]);
    endtask

    // one cycle: predict from requirements, drive, wait, compare
    task automatic step(input logic wr, input logic [71:0] w, input logic de, input logic [2:0] ds);
        int ts;
        logic rd_ok, w_ev, r_ev;
        int w_kind, w_q, w_len, r_len;
        ts = tcnt;
        rd_ok = de && (mcnt[ds] > 0);
        w_ev = 1'b0; r_ev = 1'b0; w_kind = 0; w_q = 0; w_len = 0; r_len = 0;
        if (wr) begin
            logic hdr, last;
            hdr = (w[71:64] == 8'hFF);
            last = (w[71:64] != 8'h00) && !hdr;
            if (mode == 0) begin
                if (hdr) begin
                    int d, hl, el;
                    d = int'(w[50:48]); hl = int'(w[15:0]);
                    el = (lim[d] < MAXP) ? lim[d] : MAXP;
                    if (mcnt[d] >= el || hl > D - mused[d]) begin
                        w_ev = 1'b1; w_kind = 3; w_q = d; w_len = hl; mode = 2;
                    end else begin
                        mmem[d][mt[d]] = w; mt[d] = (mt[d] + 1) % D; mused[d]++;
                        mode = 1; mcur = d; mwn = 1;
                    end
                end
            end else if (mode == 1) begin
                mmem[mcur][mt[mcur]] = w; mt[mcur] = (mt[mcur] + 1) % D; mused[mcur]++;
                mwn++;
                if (last) begin
                    mcnt[mcur]++; w_ev = 1'b1; w_kind = 1; w_q = mcur; w_len = mwn; mode = 0;
                end
            end else if (last) begin
                mode = 0;
            end
        end
        e_dv = rd_ok;
        if (rd_ok) begin
            logic [71:0] rw;
            rw = mmem[ds][mh[ds]];
            mh[ds] = (mh[ds] + 1) % D; mused[ds]--;
            e_dw = rw;
            if (rw[71:64] != 8'h00 && rw[71:64] != 8'hFF) begin
                mcnt[ds]--; r_len = mrdn[ds] + 1; mrdn[ds] = 0; r_ev = 1'b1;
            end else begin
                mrdn[ds]++;
            end
        end
        r_ev = r_ev && mon_all && mon_mask[ds];
        w_ev = w_ev && mon_all && mon_mask[w_q];
        e_r0 = '0; e_r1 = '0;
        if (r_ev) begin
            e_ev = {w_ev, 1'b1};
            e_r0 = mkrec(ts, r_len, 2, int'(ds));
            if (w_ev) e_r1 = mkrec(ts, w_len, w_kind, w_q);
        end else begin
            e_ev = {1'b0, w_ev};
            if (w_ev) e_r0 = mkrec(ts, w_len, w_kind, w_q);
        end
        in_wr = wr; in_data = w[63:0]; in_ctrl = w[71:64];
        deq_en = de; deq_sel = ds;
        @(posedge clk);
        @(negedge clk);
        chk("R2/R6 deq_valid", 72'(deq_valid), 72'(e_dv));
        if (e_dv) chk("R2 word", {deq_ctrl, deq_data}, e_dw);
        chk("R8/R10 evt_valid", 72'(evt_valid), 72'(e_ev));
        if (e_ev[0]) chk("R7/R8/R11 lane0", 72'(evt_rec[RW-1:0]), 72'(e_r0));
        if (e_ev[1]) chk("R7/R8/R11 lane1", 72'(evt_rec[2*RW-1:RW]), 72'(e_r1));
        for (int q = 0; q < 8; q++) chk("R3 count", 72'(occ_of(q)), 72'(mcnt[q]));
    endtask

    task automatic send_pkt(input int q, input int len);
        for (int i = 0; i < len; i++) step(1'b1, mkw(q, len, i), 1'b0, 3'd0);
    endtask

    task automatic drain_all();
        while (p_left > 0) begin
            step(1'b1, mkw(p_q, p_len, p_idx), 1'b0, 3'd0);
            p_idx++; p_left--;
        end
        for (int q = 0; q < 8; q++)
            while (mcnt[q] > 0) step(1'b0, 72'd0, 1'b1, 3'(q));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) begin
            lim[i] = $urandom_range(2, 16);
            mh[i] = 0; mt[i] = 0; mused[i] = 0; mcnt[i] = 0; mrdn[i] = 0;
        end
        lim[7] = 31;
        drive_limits();
        repeat (4) @(negedge clk);
        // R1: state during reset
        chk("R1 occ in reset", 72'(occ), 72'd0);
        chk("R1 evt in reset", 72'(evt_valid), 72'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 occ after reset", 72'(occ), 72'd0);
        chk("R1 deq_valid after reset", 72'(deq_valid), 72'd0);
        chk("R1 evt after reset", 72'(evt_valid), 72'd0);

        // random mix
        for (int c = 0; c < 4000; c++) begin
            logic wr;
            logic [71:0] w;
            wr = 1'b0; w = '0;
            if (c % 700 == 350) mon_mask = 8'($urandom);
            if (c % 700 == 0) mon_mask = 8'hFF;
            if (p_left == 0 && $urandom_range(0, 1) == 1) begin
                p_q = $urandom_range(0, 7); p_len = $urandom_range(2, 8);
                p_idx = 0; p_left = p_len;
            end
            if (p_left > 0 && $urandom_range(0, 3) != 0) begin
                w = mkw(p_q, p_len, p_idx); wr = 1'b1; p_idx++; p_left--;
            end
            step(wr, w, 1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)));
        end
        mon_mask = 8'hFF;
        drain_all();

        // R10: remove and store in the same cycle
        send_pkt(1, 2);
        step(1'b1, mkw(2, 2, 0), 1'b1, 3'd1);
        step(1'b1, mkw(2, 2, 1), 1'b1, 3'd1);
        chk("R10 both lanes", 72'(evt_valid), 72'd3);
        chk("R10 lane0 remove", 72'(evt_rec[4:3]), 72'd2);
        chk("R10 lane1 store", 72'(evt_rec[RW+4:RW+3]), 72'd1);
        chk("R11 timestamp", 72'(evt_rec[52:21]), 72'(tcnt - 1));
        drain_all();

        // R6: dequeue from an empty queue
        step(1'b0, 72'd0, 1'b1, 3'd0);
        chk("R6 empty dequeue", 72'(deq_valid), 72'd0);
        chk("R6 count unchanged", 72'(occ_of(0)), 72'd0);

        // R4: packet limit of two
        lim[3] = 2; drive_limits();
        send_pkt(3, 3); send_pkt(3, 3);
        step(1'b1, mkw(3, 3, 0), 1'b0, 3'd0);
        chk("R4 drop event", 72'(evt_rec[4:3]), 72'd3);
        step(1'b0, mkw(3, 3, 1), 1'b0, 3'd0);
        step(1'b1, mkw(3, 3, 1), 1'b0, 3'd0);
        step(1'b1, mkw(3, 3, 2), 1'b0, 3'd0);
        chk("R4 count at limit", 72'(occ_of(3)), 72'd2);
        drain_all();

        // R5: word space exhausted
        lim[5] = 16; drive_limits();
        send_pkt(5, 20); send_pkt(5, 20); send_pkt(5, 20);
        step(1'b1, mkw(5, 8, 0), 1'b0, 3'd0);
        chk("R5 drop event", 72'(evt_rec[4:3]), 72'd3);
        chk("R5 drop length", 72'(evt_rec[20:5]), 72'd8);
        for (int i = 1; i < 8; i++) step(1'b1, mkw(5, 8, i), 1'b0, 3'd0);
        chk("R5 count", 72'(occ_of(5)), 72'd3);
        drain_all();

        // R9: masking
        mon_all = 1'b0;
        send_pkt(4, 2);
        chk("R9 global off", 72'(evt_valid), 72'd0);
        chk("R9 stored anyway", 72'(occ_of(4)), 72'd1);
        mon_all = 1'b1; mon_mask = 8'hEF;
        send_pkt(4, 2);
        chk("R9 queue masked", 72'(evt_valid), 72'd0);
        chk("R9 stored anyway", 72'(occ_of(4)), 72'd2);
        mon_mask = 8'hFF;
        drain_all();

        step(1'b0, 72'd0, 1'b0, 3'd0);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule